// File: doc/BRIEF.md
# Codec Command Ring Fetcher

This block feeds commands to up to sixteen attached audio codecs from a circular ring of 32-bit command words kept in system memory. Software sets a 64-bit ring base, advances a write pointer and sets a run bit. The block owns the read pointer. For each new entry it issues one memory read, decodes the returned word and presents the decoded command on a codec command port with a valid/ready handshake.

A separate single-command path lets software post one word directly. That word is served ahead of any ring fetch, and its busy flag clears once the word has been handed to a codec or discarded. Words that use indirect node addressing, and words aimed at a codec that is not present, are consumed without being forwarded. An input from the response side pauses fetching while the outstanding-response quota is reached.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: A forwarded word is presented with the codec address taken from bits 31:28, the node id from bits 26:20 and the payload from bits 19:0. Words are forwarded in ring order.
- R2: A word with bit 27 set is consumed without being presented on the codec port. This applies to both the ring and the immediate path.
- R3: A word whose codec address selects a cleared bit of `codec_present` is consumed without being presented.
- R4: While `imm_busy` is set, the posted immediate word is handled before any ring fetch starts. `imm_busy` rises in the cycle after `imm_go` and clears when that word is accepted by a codec or dropped.
- R5: A ring read starts only when `run` is 1 and `rd_ptr` differs from `wr_ptr`. A change to `run` or `wr_ptr` is acted on in the next idle cycle.
- R6: No ring read starts while `quota_reached` is 1.
- R7: For each fetch the read pointer is incremented modulo 256, and the read address is `ring_base` + 4 × the new read pointer. The pointer wraps from 255 to 0.
- R8: At most one memory read is outstanding, and `rd_ptr` changes only in the cycle after read data returns.
- R9: While the codec holds `cmd_ready` low, the presented command stays stable, `rd_ptr` stays put and no further read is issued.
- R10: After reset `rd_ptr` is 0, and `imm_busy`, `mem_req_valid` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 64 | Byte address of ring entry 0 |
| wr_ptr | input | 8 | Index of the last valid entry written by software |
| run | input | 1 | Enables ring fetching |
| quota_reached | input | 1 | Outstanding-response quota reached; pauses fetching |
| codec_present | input | 16 | One bit per codec address, 1 = codec attached |
| imm_word | input | 32 | Immediate command word |
| imm_go | input | 1 | Pulse that posts `imm_word` when not busy |
| imm_busy | output | 1 | Immediate word pending |
| rd_ptr | output | 8 | Index of the last entry fetched |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Codec command valid |
| cmd_ready | input | 1 | Codec accepts the command |
| cmd_cad | output | 4 | Target codec address |
| cmd_nid | output | 7 | Target node id |
| cmd_payload | output | 20 | Command payload |

## Verification
Ring entries are generated arithmetically so that codec addresses cover all sixteen values and node ids and payloads vary. Every seventh entry carries the indirect flag, and the presence mask leaves several codecs absent, so the expected forwarded list separates correct decoding from wrongly forwarded or wrongly dropped words. A full lap past index 255 checks the wrap and every read address. Held-off phases (run low, quota reached, codec stalled) show that nothing moves. Immediate words that are forwardable, indirect or addressed to an absent codec are posted against a pending ring, which shows both the priority of that path and when its busy flag clears.

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher #(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 8,
  parameter int CAD_W  = 4,
  parameter int NID_W  = 7,
  parameter int PAY_W  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     ring_base,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic                  run,
  input  logic                  quota_reached,
  input  logic [(1<<CAD_W)-1:0] codec_present,
  input  logic [CAD_W+NID_W+PAY_W:0] imm_word,
  input  logic                  imm_go,
  output logic                  imm_busy,
  output logic [PTR_W-1:0]      rd_ptr,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [CAD_W+NID_W+PAY_W:0] mem_rsp_data,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [CAD_W-1:0]      cmd_cad,
  output logic [NID_W-1:0]      cmd_nid,
  output logic [PAY_W-1:0]      cmd_payload
);
  localparam int WORD_W = CAD_W + 1 + NID_W + PAY_W;
  localparam int IND_B  = PAY_W + NID_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_SEND} state_t;

  state_t             state;
  logic [WORD_W-1:0]  imm_reg;
  logic [WORD_W-1:0]  cmd_word;
  logic               from_imm;
  logic [PTR_W-1:0]   next_rp;
  logic               imm_ok;
  logic               rsp_ok;
  logic               ring_go;

  assign next_rp = rd_ptr + 1'b1;
  assign imm_ok  = !imm_reg[IND_B] && codec_present[imm_reg[WORD_W-1 -: CAD_W]];
  assign rsp_ok  = !mem_rsp_data[IND_B] && codec_present[mem_rsp_data[WORD_W-1 -: CAD_W]];
  assign ring_go = run && (rd_ptr != wr_ptr) && !quota_reached;

  assign mem_req_valid = (state == S_REQ);
  assign cmd_valid     = (state == S_SEND);
  assign cmd_cad       = cmd_word[WORD_W-1 -: CAD_W];
  assign cmd_nid       = cmd_word[IND_B-1 -: NID_W];
  assign cmd_payload   = cmd_word[PAY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      rd_ptr       <= '0;
      imm_busy     <= 1'b0;
      imm_reg      <= '0;
      cmd_word     <= '0;
      from_imm     <= 1'b0;
      mem_req_addr <= '0;
    end else begin
      if (imm_go && !imm_busy) begin
        imm_busy <= 1'b1;
        imm_reg  <= imm_word;
      end
      case (state)
        S_IDLE: begin
          if (imm_busy) begin
            if (imm_ok) begin
              cmd_word <= imm_reg;
              from_imm <= 1'b1;
              state    <= S_SEND;
            end else begin
              imm_busy <= 1'b0;
            end
          end else if (ring_go) begin
            mem_req_addr <= ring_base + ADDR_W'({next_rp, 2'b00});
            state        <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: begin
          if (mem_rsp_valid) begin
            rd_ptr <= next_rp;
            if (rsp_ok) begin
              cmd_word <= mem_rsp_data;
              from_imm <= 1'b0;
              state    <= S_SEND;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_SEND: begin
          if (cmd_ready) begin
            if (from_imm) imm_busy <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_ring_fetcher_chk.sv
module cmd_ring_fetcher_chk #(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 8,
  parameter int CAD_W  = 4,
  parameter int NID_W  = 7,
  parameter int PAY_W  = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PTR_W-1:0]      wr_ptr,
  input logic                  run,
  input logic                  quota_reached,
  input logic [(1<<CAD_W)-1:0] codec_present,
  input logic [PTR_W-1:0]      rd_ptr,
  input logic                  mem_req_valid,
  input logic                  mem_req_ready,
  input logic [ADDR_W-1:0]     mem_req_addr,
  input logic                  mem_rsp_valid,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [CAD_W-1:0]      cmd_cad,
  input logic [NID_W-1:0]      cmd_nid,
  input logic [PAY_W-1:0]      cmd_payload
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)) && $past(mem_rsp_valid));

  a_r5_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(run) && ($past(rd_ptr) != $past(wr_ptr)));

  a_r6_quota_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(quota_reached));

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_cad) && $stable(cmd_nid) && $stable(cmd_payload));

  a_r9_no_fetch_while_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req_valid);

  a_r3_present_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> codec_present[cmd_cad]);
endmodule

bind cmd_ring_fetcher cmd_ring_fetcher_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CAD_W(CAD_W), .NID_W(NID_W), .PAY_W(PAY_W)
) u_chk (.*);

// File: tb/tb_cmd_ring_fetcher.sv
`timescale 1ns/1ps
module tb_cmd_ring_fetcher;
  localparam logic [63:0] BASE    = 64'h1234_5678_9ABC_0000;
  localparam logic [15:0] PRESENT = 16'hB5F3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  wr_ptr = 0;
  logic        run = 0;
  logic        quota_reached = 0;
  logic [31:0] imm_word = 0;
  logic        imm_go = 0;
  logic        imm_busy;
  logic [7:0]  rd_ptr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        cmd_valid;
  logic        cmd_ready = 1;
  logic [3:0]  cmd_cad;
  logic [6:0]  cmd_nid;
  logic [19:0] cmd_payload;

  always #10 clk = ~clk;

  cmd_ring_fetcher dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .wr_ptr(wr_ptr), .run(run),
    .quota_reached(quota_reached), .codec_present(PRESENT),
    .imm_word(imm_word), .imm_go(imm_go), .imm_busy(imm_busy), .rd_ptr(rd_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cad(cmd_cad), .cmd_nid(cmd_nid), .cmd_payload(cmd_payload)
  );

  int checks = 0;
  int fails = 0;

  function automatic logic [31:0] ringw(int i);
    logic [3:0] c;
    c = 4'(i) ^ 4'(i >> 4);
    return {c, (i % 7 == 3), 7'((i * 37 + 5) % 128), 20'(i * 40503 + 17)};
  endfunction

  function automatic bit fwd(logic [31:0] w);
    return !w[27] && PRESENT[w[31:28]];
  endfunction

  function automatic logic [30:0] pack(logic [31:0] w);
    return {w[31:28], w[26:20], w[19:0]};
  endfunction

  // memory responder: one cycle latency, checks R7 address sequence
  int mdl_rp = 0;
  int req_n = 0;
  int addr_bad = 0;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      req_n <= req_n + 1;
      if (mem_req_addr != BASE + 64'(((mdl_rp + 1) % 256) * 4)) addr_bad <= addr_bad + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= ringw(32'((mem_req_addr - BASE) >> 2) % 256);
      mdl_rp <= (mdl_rp + 1) % 256;
    end
  end

  // codec model: logs accepted commands
  logic [30:0] log_q [0:1023];
  int log_n = 0;
  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      log_q[log_n] <= {cmd_cad, cmd_nid, cmd_payload};
      log_n <= log_n + 1;
    end
  end

  logic [30:0] exp_q [0:1023];
  int exp_n = 0;
  int cmp_n = 0;
  int exp_rp = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic compare_log();
    chk(log_n == exp_n, "R1", "forwarded count", log_n, exp_n);
    for (int i = cmp_n; i < log_n && i < exp_n; i++)
      chk(log_q[i] == exp_q[i], "R1/R2/R3", "command fields", log_q[i], exp_q[i]);
    cmp_n = log_n;
  endtask

  task automatic advance(int target);
    int idx;
    idx = exp_rp;
    wr_ptr = 8'(target);
    while (idx != target) begin
      idx = (idx + 1) % 256;
      if (fwd(ringw(idx))) begin
        exp_q[exp_n] = pack(ringw(idx));
        exp_n++;
      end
    end
    for (int t = 0; t < 4000 && rd_ptr != 8'(target); t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(rd_ptr == 8'(target), "R7", "read pointer after run", rd_ptr, target);
    exp_rp = target;
    compare_log();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int first, tgt, saved;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(rd_ptr == 0, "R10", "rd_ptr", rd_ptr, 0);
    chk(!imm_busy && !mem_req_valid && !cmd_valid, "R10", "idle outputs",
        {imm_busy, mem_req_valid, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R5: run low, pending entries
    wr_ptr = 8'd5;
    repeat (20) @(negedge clk);
    chk(rd_ptr == 0 && req_n == 0, "R5", "no fetch while stopped", rd_ptr, 0);
    run = 1;
    advance(5);
    advance(45);

    // R6: quota reached holds fetch
    quota_reached = 1;
    tgt = (exp_rp + 4) % 256;
    saved = req_n;
    wr_ptr = 8'(tgt);
    repeat (20) @(negedge clk);
    chk(rd_ptr == 8'(exp_rp) && req_n == saved, "R6", "no fetch at quota", rd_ptr, exp_rp);
    quota_reached = 0;
    advance(tgt);

    // R7: full lap through 255 -> 0
    advance(0);
    advance(3);
    chk(addr_bad == 0, "R7", "read addresses", addr_bad, 0);

    // R9: stalled codec
    cmd_ready = 0;
    first = (exp_rp + 1) % 256;
    while (!fwd(ringw(first))) first = (first + 1) % 256;
    tgt = (first + 2) % 256;
    wr_ptr = 8'(tgt);
    repeat (30) @(negedge clk);
    chk(cmd_valid == 1, "R9", "command held valid", cmd_valid, 1);
    chk(rd_ptr == 8'(first), "R9", "pointer held", rd_ptr, first);
    saved = req_n;
    repeat (10) @(negedge clk);
    chk(req_n == saved, "R8", "no read while codec stalled", req_n, saved);
    chk({cmd_cad, cmd_nid, cmd_payload} == pack(ringw(first)), "R9", "held fields",
        {cmd_cad, cmd_nid, cmd_payload}, pack(ringw(first)));
    cmd_ready = 1;
    advance(tgt);

    // R4: immediate ahead of pending ring entries
    run = 0;
    tgt = (exp_rp + 3) % 256;
    wr_ptr = 8'(tgt);
    imm_word = {4'd0, 1'b0, 7'h55, 20'hABCDE};
    imm_go = 1;
    @(negedge clk);
    imm_go = 0;
    run = 1;
    chk(imm_busy == 1, "R4", "busy after post", imm_busy, 1);
    exp_q[exp_n] = pack(imm_word);
    exp_n++;
    advance(tgt);
    chk(imm_busy == 0, "R4", "busy cleared after accept", imm_busy, 0);

    // R3/R4: immediate to absent codec (address 2)
    saved = log_n;
    imm_word = {4'd2, 1'b0, 7'h11, 20'h12345};
    imm_go = 1;
    @(negedge clk);
    imm_go = 0;
    repeat (6) @(negedge clk);
    chk(imm_busy == 0 && log_n == saved, "R3", "absent codec immediate dropped", log_n, saved);

    // R2/R4: immediate with indirect flag
    imm_word = {4'd0, 1'b1, 7'h22, 20'h54321};
    imm_go = 1;
    @(negedge clk);
    imm_go = 0;
    repeat (6) @(negedge clk);
    chk(imm_busy == 0 && log_n == saved, "R2", "indirect immediate dropped", log_n, saved);
    compare_log();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule